// File: doc/BRIEF.md
# Indexed-Port Watchdog Timer

This block is a watchdog timer that software reaches only through a two-byte register window. A write to the first byte selects one of the internal 8-bit registers. A read or write of the second byte then reaches the register that was selected. The timer counts strobes on a slow tick-enable input, which runs at 32768 Hz in a typical system. It is loaded from a 24-bit timeout that is stored as the wanted tick count minus one. When the timeout runs out, the block sends a one-cycle pulse on its interrupt output or on its reset output, whichever the select field chooses. It also raises a sticky fired flag.

Software updates every control register by read-modify-write, so each stored bit reads back as it was last written. The restart request is a write-only strobe that lives in the same register as the fired flag. The register window is a plain single-cycle port. A read returns data combinationally in the cycle in which the read strobe is high. A write takes effect at the clock edge that ends the cycle. The port has no back-pressure and no wait states.

Register indexes (hex): 37 control, 38 signal select, 39/3A/3B timeout bytes (low, middle, high), 3C command/status.

Top module: `wdt_ix_top`

## Requirements
- R1: After reset all registers read 0, the register index is 0, and both pulse outputs are low.
- R2: A write with `bus_addr`=0 loads the index, and a read with `bus_addr`=0 returns it. With `bus_addr`=1, a read or write reaches the indexed register. `bus_rdata` is valid in the same cycle as `bus_rd` and is 0 when `bus_rd` is low. Registers 37, 38, 39, 3A and 3B read back the full byte last written. Any index outside 37..3C reads 0 and ignores writes.
- R3: When the upper nibble of register 38 is D, an expiry drives `reset_pulse` high for exactly one cycle. The pulse appears in the cycle after the clock edge that takes the expiring tick.
- R4: When the upper nibble of register 38 is C, an expiry drives `nmi_pulse` high for one cycle instead. Any other nibble value gives no pulse, but the fired flag is still set.
- R5: Bit 6 of register 37 enables the timer. Writing that bit from 0 to 1 loads the counter from the timeout. While the bit is 0, ticks are ignored and no pulse is produced.
- R6: Writing 1 to bit 6 of register 3C reloads the counter from the timeout. That bit always reads back as 0.
- R7: Bit 7 of register 3C is the fired flag. It is set by an expiry and stays set. Writing 0 to it clears it, and writing 1 to it has no effect. Bits 5:0 of register 3C are plain storage.
- R8: If an expiry and a write that clears the fired flag fall in the same cycle, the flag ends up set.
- R9: If a reload write falls in the same cycle as the tick that would expire the timer, the reload wins: no expiry happens, and a full timeout starts again.
- R10: With timeout value N, the (N+1)th counted tick after a load expires the timer. The counter then reloads by itself, so expiries repeat every N+1 ticks. N=0 expires on every tick.
- R11: The timeout uses all 24 bits: register 39 holds bits 7:0, 3A holds bits 15:8 and 3B holds bits 23:16.
- R12: `nmi_pulse` and `reset_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one cycle per timer tick |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_rd | input | 1 | Read strobe for the register window |
| bus_addr | input | 1 | Window offset: 0 index, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| nmi_pulse | output | 1 | One-cycle interrupt pulse on expiry |
| reset_pulse | output | 1 | One-cycle reset pulse on expiry |

## Verification
Two pairs of functions can meet in one cycle: an expiry tick with a data write that clears the fired flag, and an expiry tick with a reload write. The bench provokes each collision by first running the counter down to zero. It then holds `tick` high during the very cycle of the data write to register 3C. For the clear collision, the bench expects a pulse and a fired flag that still reads set. For the reload collision, it expects no pulse, and then a fresh run of N+1 ticks before the next expiry.

// File: rtl/wdt_ix_pkg.sv
package wdt_ix_pkg;
  localparam int unsigned DW = 8;
  localparam logic [DW-1:0] IX_CTL  = 8'h37;
  localparam logic [DW-1:0] IX_SEL  = 8'h38;
  localparam logic [DW-1:0] IX_TMO0 = 8'h39;
  localparam logic [DW-1:0] IX_CMD  = 8'h3C;
  localparam int unsigned EN_BIT     = 6;
  localparam int unsigned RELOAD_BIT = 6;
  localparam int unsigned FIRED_BIT  = 7;
  localparam logic [3:0] SEL_NMI = 4'hC;
  localparam logic [3:0] SEL_RST = 4'hD;
endpackage

// File: rtl/wdt_ix_regs.sv
module wdt_ix_regs
  import wdt_ix_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             fired_i,
  output logic             en_o,
  output logic [3:0]       sel_o,
  output logic [CNT_W-1:0] tmo_o,
  output logic             reload_o,
  output logic             en_rise_o,
  output logic             fired_clr_o,
  output logic [DW-1:0]    idx_o
);
  localparam int unsigned NB = CNT_W / DW;

  logic [DW-1:0] idx_q, ctl_q, sel_q;
  logic [5:0]    cmd_q;
  logic [DW-1:0] tmo_q [NB];

  logic dwr, iwr;
  assign dwr = wr_en && addr;
  assign iwr = wr_en && !addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ctl_q <= '0;
      sel_q <= '0;
      cmd_q <= '0;
    end else begin
      if (iwr) idx_q <= wdata;
      if (dwr) begin
        if (idx_q == IX_CTL) ctl_q <= wdata;
        if (idx_q == IX_SEL) sel_q <= wdata;
        if (idx_q == IX_CMD) cmd_q <= wdata[5:0];
      end
    end
  end

  for (genvar gb = 0; gb < NB; gb++) begin : g_tmo
    always_ff @(posedge clk) begin
      if (!rst_n) tmo_q[gb] <= '0;
      else if (dwr && idx_q == IX_TMO0 + DW'(gb)) tmo_q[gb] <= wdata;
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) tmo_o[b*DW +: DW] = tmo_q[b];
  end

  assign en_o        = ctl_q[EN_BIT];
  assign sel_o       = sel_q[7:4];
  assign idx_o       = idx_q;
  assign reload_o    = dwr && idx_q == IX_CMD && wdata[RELOAD_BIT];
  assign fired_clr_o = dwr && idx_q == IX_CMD && !wdata[FIRED_BIT];
  assign en_rise_o   = dwr && idx_q == IX_CTL && wdata[EN_BIT] && !ctl_q[EN_BIT];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (!addr) begin
        rdata = idx_q;
      end else if (idx_q == IX_CTL) begin
        rdata = ctl_q;
      end else if (idx_q == IX_SEL) begin
        rdata = sel_q;
      end else if (idx_q == IX_CMD) begin
        rdata = {fired_i, 1'b0, cmd_q};
      end else begin
        for (int b = 0; b < NB; b++)
          if (idx_q == IX_TMO0 + DW'(b)) rdata = tmo_q[b];
      end
    end
  end
endmodule

// File: rtl/wdt_ix_count.sv
module wdt_ix_count
  import wdt_ix_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             en_rise,
  input  logic             reload,
  input  logic [CNT_W-1:0] tmo,
  input  logic [3:0]       sel,
  input  logic             fired_clr,
  output logic             nmi_o,
  output logic             rst_o,
  output logic             fired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic step, expire;

  assign step   = en && tick;
  assign expire = step && (cnt_q == '0) && !reload && !en_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      nmi_o   <= 1'b0;
      rst_o   <= 1'b0;
      fired_o <= 1'b0;
    end else begin
      nmi_o <= expire && sel == SEL_NMI;
      rst_o <= expire && sel == SEL_RST;
      if (expire) fired_o <= 1'b1;
      else if (fired_clr) fired_o <= 1'b0;
      if (reload || en_rise || expire) cnt_q <= tmo;
      else if (step) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ix_top.sv
module wdt_ix_top
  import wdt_ix_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          nmi_pulse,
  output logic          reset_pulse
);
  logic             ctl_en, en_rise, reload, fired_clr, fired;
  logic [3:0]       sel_nib;
  logic [CNT_W-1:0] tmo;
  logic [DW-1:0]    cur_idx;

  wdt_ix_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .fired_i(fired), .en_o(ctl_en), .sel_o(sel_nib), .tmo_o(tmo),
    .reload_o(reload), .en_rise_o(en_rise), .fired_clr_o(fired_clr),
    .idx_o(cur_idx)
  );

  wdt_ix_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctl_en),
    .en_rise(en_rise), .reload(reload), .tmo(tmo), .sel(sel_nib),
    .fired_clr(fired_clr), .nmi_o(nmi_pulse), .rst_o(reset_pulse),
    .fired_o(fired)
  );
endmodule

// File: rtl/wdt_ix_chk.sv
module wdt_ix_chk
  import wdt_ix_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          fired,
  input logic          nmi_o,
  input logic          rst_o,
  input logic          rd_en,
  input logic          addr,
  input logic [DW-1:0] idx,
  input logic [DW-1:0] rdata
);
  a_r12_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_o && rst_o));

  a_r3_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |=> !rst_o);

  a_r4_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |=> !nmi_o);

  a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(nmi_o || rst_o));

  a_r7_fired_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o || rst_o) |-> fired);

  a_r6_reload_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr && idx == IX_CMD) |-> !rdata[RELOAD_BIT]);
endmodule

bind wdt_ix_top wdt_ix_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_en), .fired(fired),
  .nmi_o(nmi_pulse), .rst_o(reset_pulse), .rd_en(bus_rd),
  .addr(bus_addr), .idx(cur_idx), .rdata(bus_rdata)
);

// File: tb/wdt_ix_top_bench.sv
module wdt_ix_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic nmi_pulse, reset_pulse;

  int checks = 0, failures = 0;
  int n_seen = 0, r_seen = 0;
  logic last_nmi = 1'b0, last_rst = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_ix_top u_wdt_ix_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_pulse(nmi_pulse), .reset_pulse(reset_pulse)
  );

  always @(negedge clk) begin
    if (nmi_pulse) n_seen++;
    if (reset_pulse) r_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d, input logic t = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = t;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    last_nmi = nmi_pulse; last_rst = reset_pulse;
    #1;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [7:0] d);
    bus_write(1'b0, ix);
    bus_write(1'b1, d);
  endtask

  task automatic rreg(input logic [7:0] ix, output logic [7:0] d);
    bus_write(1'b0, ix);
    bus_read(1'b1, d);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    last_nmi = nmi_pulse; last_rst = reset_pulse;
    #1;
  endtask

  task automatic arm(input logic [23:0] tmo, input logic [7:0] sel);
    wreg(8'h37, 8'h00);
    wreg(8'h39, tmo[7:0]);
    wreg(8'h3A, tmo[15:8]);
    wreg(8'h3B, tmo[23:16]);
    wreg(8'h38, sel);
    wreg(8'h37, 8'h40);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(nmi_pulse == 0 && reset_pulse == 0, "R1 outputs", {nmi_pulse, reset_pulse}, 0);
    bus_read(1'b0, d);
    chk(d == 8'h00, "R1 index", d, 0);
    for (int ix = 8'h37; ix <= 8'h3C; ix++) begin
      rreg(8'(ix), d);
      chk(d == 8'h00, "R1 register", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wreg(8'h37, 8'h15); wreg(8'h38, 8'hA5);
    wreg(8'h39, 8'h12); wreg(8'h3A, 8'h34); wreg(8'h3B, 8'h56);
    wreg(8'h3C, 8'h2A);
    rreg(8'h37, d); chk(d == 8'h15, "R2 reg37", d, 8'h15);
    rreg(8'h38, d); chk(d == 8'hA5, "R2 reg38", d, 8'hA5);
    rreg(8'h39, d); chk(d == 8'h12, "R11 reg39", d, 8'h12);
    rreg(8'h3A, d); chk(d == 8'h34, "R11 reg3A", d, 8'h34);
    rreg(8'h3B, d); chk(d == 8'h56, "R11 reg3B", d, 8'h56);
    rreg(8'h3C, d); chk(d == 8'h2A, "R7 reg3C low bits", d, 8'h2A);
    wreg(8'h40, 8'h7F);
    rreg(8'h40, d); chk(d == 8'h00, "R2 unimplemented", d, 0);
    bus_read(1'b0, d); chk(d == 8'h40, "R2 index readback", d, 8'h40);
    @(negedge clk); #1;
    chk(bus_rdata == 8'h00, "R2 idle rdata", bus_rdata, 0);
  endtask

  task automatic t_rst_expiry();
    logic [7:0] d;
    int r0;
    arm(24'd2, 8'hD0);
    r0 = r_seen + n_seen;
    do_tick(); do_tick();
    chk(r_seen + n_seen == r0, "R10 no early expiry", r_seen + n_seen - r0, 0);
    do_tick();
    chk(last_rst == 1 && last_nmi == 0, "R3 reset pulse", {last_nmi, last_rst}, 1);
    @(negedge clk); #1;
    chk(reset_pulse == 0, "R3 single cycle", reset_pulse, 0);
    rreg(8'h3C, d); chk(d == 8'hAA, "R7 fired set", d, 8'hAA);
    do_tick(); do_tick();
    chk(last_rst == 0, "R10 periodic early", last_rst, 0);
    do_tick();
    chk(last_rst == 1, "R10 periodic reload", last_rst, 1);
  endtask

  task automatic t_fired();
    logic [7:0] d;
    wreg(8'h3C, 8'hEA);
    rreg(8'h3C, d); chk(d == 8'hAA, "R6 reload reads 0, R7 write 1 keeps", d, 8'hAA);
    wreg(8'h3C, 8'h2A);
    rreg(8'h3C, d); chk(d == 8'h2A, "R7 fired cleared", d, 8'h2A);
  endtask

  task automatic t_nmi();
    arm(24'd0, 8'hC0);
    do_tick();
    chk(last_nmi == 1 && last_rst == 0, "R4 nmi pulse", {last_nmi, last_rst}, 2);
    do_tick();
    chk(last_nmi == 1, "R10 zero timeout every tick", last_nmi, 1);
  endtask

  task automatic t_other_sel();
    logic [7:0] d;
    int s0;
    wreg(8'h3C, 8'h00);
    wreg(8'h38, 8'h30);
    s0 = r_seen + n_seen;
    do_tick();
    chk(r_seen + n_seen == s0, "R4 other select no pulse", r_seen + n_seen - s0, 0);
    rreg(8'h3C, d); chk(d == 8'h80, "R4 other select sets fired", d, 8'h80);
  endtask

  task automatic t_disable();
    int s0;
    wreg(8'h38, 8'hC0);
    wreg(8'h37, 8'h00);
    s0 = r_seen + n_seen;
    for (int i = 0; i < 5; i++) do_tick();
    chk(r_seen + n_seen == s0, "R5 disabled quiet", r_seen + n_seen - s0, 0);
  endtask

  task automatic t_reload();
    arm(24'd2, 8'hD0);
    do_tick(); do_tick();
    wreg(8'h3C, 8'h40);
    do_tick(); do_tick();
    chk(last_rst == 0, "R6 reload restarts", last_rst, 0);
    do_tick();
    chk(last_rst == 1, "R6 expiry after reload", last_rst, 1);
  endtask

  task automatic t_reload_collide();
    arm(24'd2, 8'hD0);
    do_tick(); do_tick();
    bus_write(1'b0, 8'h3C);
    bus_write(1'b1, 8'h40, 1'b1);
    chk(last_rst == 0, "R9 reload beats expiry", last_rst, 0);
    do_tick(); do_tick();
    chk(last_rst == 0, "R9 full restart", last_rst, 0);
    do_tick();
    chk(last_rst == 1, "R9 expiry after restart", last_rst, 1);
  endtask

  task automatic t_fired_collide();
    logic [7:0] d;
    arm(24'd0, 8'hD0);
    wreg(8'h3C, 8'h00);
    bus_write(1'b0, 8'h3C);
    bus_write(1'b1, 8'h00, 1'b1);
    chk(last_rst == 1, "R8 expiry in collision", last_rst, 1);
    rreg(8'h3C, d); chk(d == 8'h80, "R8 set beats clear", d, 8'h80);
    wreg(8'h3C, 8'h00);
    rreg(8'h3C, d); chk(d == 8'h00, "R8 later clear", d, 0);
  endtask

  task automatic t_long();
    int s0;
    arm(24'h010000, 8'hD0);
    @(negedge clk);
    tick = 1'b1;
    s0 = r_seen + n_seen;
    repeat (65536) @(negedge clk);
    #1;
    chk(r_seen + n_seen == s0 && reset_pulse == 0, "R11 no early expiry",
        r_seen + n_seen - s0, 0);
    @(negedge clk);
    tick = 1'b0;
    #1;
    chk(reset_pulse == 1 && nmi_pulse == 0, "R11 24-bit expiry", reset_pulse, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_rst_expiry();
    t_fired();
    t_nmi();
    t_other_sel();
    t_disable();
    t_reload();
    t_reload_collide();
    t_fired_collide();
    t_long();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule